// File: doc/BRIEF.md
# SPI Serial Memory Slave Engine

This block is the serial front end of a 512-byte nonvolatile memory. It takes a four-wire SPI link in clock modes 0 and 3. It decodes a one-byte command and, where the command needs one, a two-byte address. It then either streams array bytes out on the serial output or gathers bytes that a separate protection and status controller acts on.

Every SPI pin is synchronised into a fast system clock and edge-detected. The block is never clocked from the serial clock. Reads are served from a synchronous 512x8 register array. The controller fills that array through a plain write port.

Writes are never performed here. A sector program, a status write or a program-enable change leaves the block as a one-cycle request pulse. That pulse appears only when chip select is released at exactly the right bit count.

Top module: `spi_mem_slave`

## Requirements
- R1: The input line is sampled on rising serial-clock edges and the output line changes only after falling edges, most significant bit first. Behaviour is the same whether the clock idles low (mode 0) or high (mode 3).
- R2: `spi_so_oe` is 0 whenever chip select is high. It is 1 only while read data or status is being shifted out. A command byte other than 0x01..0x06 leaves it at 0 and raises no request.
- R3: Command 0x03 is followed by a 16-bit address whose low 9 bits select the byte, so bits 15:9 are ignored. Output stream bit 0 is presented before the 25th rising clock edge. The address then increments after every byte and wraps from 0x1FF to 0x000.
- R4: Command 0x05 shifts out `stat_byte` MSB first and repeats it every 8 bits. While `nv_busy` is 1, every bit shifted out is 1.
- R5: Command 0x06 pulses `en_set` and command 0x04 pulses `en_clr` for one cycle. Either pulse occurs only if chip select rises after exactly 8 clock bits.
- R6: Command 0x01 followed by one or more whole data bytes pulses `stat_wr` with the last byte on `stat_wdata` when chip select rises on a byte boundary.
- R7: Command 0x02 with address A and 16 data bytes pulses `prog_req` with `prog_base` = A with bits 3:0 cleared. Data byte k goes to `prog_data[8*s+7:8*s]`, where s = (A[3:0]+k) mod 16.
- R8: A program, status write or enable command whose chip-select rise comes at any other bit count (for example 151 or 160 bits for a program, or 8 bits for a status write) raises no request.
- R9: After reset, no command is accepted until a high-to-low chip-select transition is seen.
- R10: Bytes written through `arr_we`/`arr_waddr`/`arr_wdata` are returned by later reads.
- R11: At most one request output is high in any cycle, and each request lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Drive enable for the serial output pad |
| nv_busy | input | 1 | Controller reports a nonvolatile write in progress |
| stat_byte | input | 8 | Current protection/status byte |
| arr_we | input | 1 | Array write strobe from the controller |
| arr_waddr | input | ADDR_W | Array write address |
| arr_wdata | input | 8 | Array write data |
| en_set | output | 1 | Request: set program enable |
| en_clr | output | 1 | Request: clear program enable |
| stat_wr | output | 1 | Request: write status byte |
| stat_wdata | output | 8 | Status byte to write |
| prog_req | output | 1 | Request: program one sector |
| prog_base | output | ADDR_W | Sector base address |
| prog_data | output | 8*SECT_LEN | Sector bytes, slot s at bits 8s+7:8s |

## Verification
The bound checker watches several rules on every cycle. It holds the output at high impedance while deselected, and lets the output change only after a detected falling edge. It also confirms that requests are single-cycle and mutually exclusive, appear only right after a chip-select rise, and carry a sector-aligned base. The values shifted out cannot be shown by a property: the 9-bit wrap, status repetition and the all-ones busy pattern are all left to the bench. The exact-count commit rules, the slot rotation inside a sector and the need for a chip-select fall after reset are likewise shown only by bench scenarios.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
    localparam logic [7:0] OP_EN_SET  = 8'h06;
    localparam logic [7:0] OP_EN_CLR  = 8'h04;
    localparam logic [7:0] OP_STAT_WR = 8'h01;
    localparam logic [7:0] OP_STAT_RD = 8'h05;
    localparam logic [7:0] OP_PROG    = 8'h02;
    localparam logic [7:0] OP_READ    = 8'h03;

    localparam int OPC_BITS  = 8;
    localparam int ADDR_BITS = 16;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_RDATA,
        PH_PDATA,
        PH_RSTAT,
        PH_WSTAT,
        PH_CMD,
        PH_SKIP
    } phase_e;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], din};
        end
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells_q[waddr] <= wdata;
        end
        rdata <= cells_q[raddr];
    end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int SECT_LEN    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spi_sck,
    input  logic                    spi_cs_n,
    input  logic                    spi_si,
    output logic                    spi_so,
    output logic                    spi_so_oe,
    input  logic                    nv_busy,
    input  logic [7:0]              stat_byte,
    input  logic                    arr_we,
    input  logic [ADDR_W-1:0]       arr_waddr,
    input  logic [7:0]              arr_wdata,
    output logic                    en_set,
    output logic                    en_clr,
    output logic                    stat_wr,
    output logic [7:0]              stat_wdata,
    output logic                    prog_req,
    output logic [ADDR_W-1:0]       prog_base,
    output logic [8*SECT_LEN-1:0]   prog_data
);
    localparam int SECT_W    = $clog2(SECT_LEN);
    localparam int BUF_W     = 8 * SECT_LEN;
    localparam int PROG_BITS = OPC_BITS + ADDR_BITS + BUF_W;
    localparam int CNT_W     = $clog2(PROG_BITS) + 1;
    localparam logic [CNT_W-1:0] CNT_OPC  = CNT_W'(OPC_BITS);
    localparam logic [CNT_W-1:0] CNT_ALST = CNT_W'(OPC_BITS + ADDR_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_STW  = CNT_W'(2 * OPC_BITS);
    localparam logic [CNT_W-1:0] CNT_PROG = CNT_W'(PROG_BITS);

    typedef struct packed {
        phase_e              ph;
        logic                sck_prev;
        logic                cs_prev;
        logic [CNT_W-1:0]    nbits;
        logic [7:0]          shreg;
        logic [7:0]          opc;
        logic [ADDR_W-1:0]   addr;
        logic [ADDR_W-1:0]   rd_addr;
        logic [2:0]          oidx;
        logic [SECT_W-1:0]   slot;
        logic [BUF_W-1:0]    buffer;
        logic [7:0]          last_byte;
        logic                so;
        logic                so_oe;
        logic                en_set;
        logic                en_clr;
        logic                stat_wr;
        logic [7:0]          stat_wdata;
        logic                prog_req;
        logic [ADDR_W-1:0]   prog_base;
        logic [BUF_W-1:0]    prog_data;
    } slv_state_t;

    slv_state_t q, d;

    logic sck_s, cs_s, si_s;
    logic sck_rise, sck_fall, cs_rise, cs_fall;
    logic [7:0] rdata;

    // Chip select resets low so a select held low through reset is not seen as a fall.
    spi_mem_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .din(spi_sck), .dout(sck_s));
    spi_mem_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .din(spi_cs_n), .dout(cs_s));
    spi_mem_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_si (
        .clk(clk), .rst_n(rst_n), .din(spi_si), .dout(si_s));

    spi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
        .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
        .raddr(q.rd_addr), .rdata(rdata));

    assign sck_rise = sck_s & ~q.sck_prev;
    assign sck_fall = ~sck_s & q.sck_prev;
    assign cs_rise  = cs_s & ~q.cs_prev;
    assign cs_fall  = ~cs_s & q.cs_prev;

    always_comb begin
        logic [7:0]        sh;
        logic              byte_done;
        logic [ADDR_W-1:0] addr_nx;

        d          = q;
        d.sck_prev = sck_s;
        d.cs_prev  = cs_s;
        d.en_set   = 1'b0;
        d.en_clr   = 1'b0;
        d.stat_wr  = 1'b0;
        d.prog_req = 1'b0;

        sh        = {q.shreg[6:0], si_s};
        byte_done = (q.nbits[2:0] == 3'd7);
        addr_nx   = {q.addr[ADDR_W-2:0], si_s};

        if (cs_fall) begin
            d.ph    = PH_OPC;
            d.nbits = '0;
            d.oidx  = '0;
        end else if (cs_rise) begin
            case (q.ph)
                PH_CMD: begin
                    if (q.nbits == CNT_OPC) begin
                        d.en_set = (q.opc == OP_EN_SET);
                        d.en_clr = (q.opc == OP_EN_CLR);
                    end
                end
                PH_WSTAT: begin
                    if ((q.nbits[2:0] == 3'd0) && (q.nbits >= CNT_STW)) begin
                        d.stat_wr    = 1'b1;
                        d.stat_wdata = q.last_byte;
                    end
                end
                PH_PDATA: begin
                    if (q.nbits == CNT_PROG) begin
                        d.prog_req  = 1'b1;
                        d.prog_base = {q.addr[ADDR_W-1:SECT_W], {SECT_W{1'b0}}};
                        d.prog_data = q.buffer;
                    end
                end
                default: ;
            endcase
            d.ph = PH_IDLE;
        end else if (!cs_s && (q.ph != PH_IDLE)) begin
            if (sck_rise) begin
                d.shreg = sh;
                if (q.nbits != '1) begin
                    d.nbits = q.nbits + 1'b1;
                end
                case (q.ph)
                    PH_OPC: begin
                        if (byte_done) begin
                            d.opc = sh;
                            case (sh)
                                OP_READ, OP_PROG:     d.ph = PH_ADDR;
                                OP_STAT_RD: begin
                                    d.ph   = PH_RSTAT;
                                    d.oidx = '0;
                                end
                                OP_STAT_WR:           d.ph = PH_WSTAT;
                                OP_EN_SET, OP_EN_CLR: d.ph = PH_CMD;
                                default:              d.ph = PH_SKIP;
                            endcase
                        end
                    end
                    PH_ADDR: begin
                        d.addr = addr_nx;
                        if (q.nbits == CNT_ALST) begin
                            if (q.opc == OP_READ) begin
                                d.ph      = PH_RDATA;
                                d.rd_addr = addr_nx;
                                d.oidx    = '0;
                            end else begin
                                d.ph   = PH_PDATA;
                                d.slot = addr_nx[SECT_W-1:0];
                            end
                        end
                    end
                    PH_PDATA: begin
                        if (byte_done) begin
                            d.buffer[q.slot*8 +: 8] = sh;
                            d.slot = q.slot + 1'b1;
                        end
                    end
                    PH_WSTAT: begin
                        if (byte_done) begin
                            d.last_byte = sh;
                        end
                    end
                    default: ;
                endcase
            end else if (sck_fall) begin
                case (q.ph)
                    PH_RDATA: begin
                        d.so   = rdata[~q.oidx];
                        d.oidx = q.oidx + 1'b1;
                        if (q.oidx == 3'd7) begin
                            d.rd_addr = q.rd_addr + 1'b1;
                        end
                    end
                    PH_RSTAT: begin
                        d.so   = nv_busy ? 1'b1 : stat_byte[~q.oidx];
                        d.oidx = q.oidx + 1'b1;
                    end
                    default: ;
                endcase
            end
        end

        d.so_oe = !cs_s && ((d.ph == PH_RDATA) || (d.ph == PH_RSTAT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.ph       <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign spi_so     = q.so;
    assign spi_so_oe  = q.so_oe;
    assign en_set     = q.en_set;
    assign en_clr     = q.en_clr;
    assign stat_wr    = q.stat_wr;
    assign stat_wdata = q.stat_wdata;
    assign prog_req   = q.prog_req;
    assign prog_base  = q.prog_base;
    assign prog_data  = q.prog_data;
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk #(
    parameter int ADDR_W   = 9,
    parameter int SECT_LEN = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_s,
    input logic              cs_rise,
    input logic              sck_fall,
    input logic              spi_so,
    input logic              spi_so_oe,
    input logic              en_set,
    input logic              en_clr,
    input logic              stat_wr,
    input logic              prog_req,
    input logic [ADDR_W-1:0] prog_base
);
    localparam int SECT_W = $clog2(SECT_LEN);

    AST_HIZ_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !spi_so_oe); // R2

    AST_SO_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_so_oe && $past(spi_so_oe) && !$past(sck_fall)) |-> $stable(spi_so)); // R1

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_set, en_clr, stat_wr, prog_req})); // R11

    AST_REQ_AFTER_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set || en_clr || stat_wr || prog_req) |-> $past(cs_rise)); // R8

    AST_PROG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req); // R11

    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> (prog_base[SECT_W-1:0] == '0)); // R7
endmodule

bind spi_mem_slave spi_mem_slave_chk #(.ADDR_W(ADDR_W), .SECT_LEN(SECT_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_rise(cs_rise), .sck_fall(sck_fall),
    .spi_so(spi_so), .spi_so_oe(spi_so_oe), .en_set(en_set), .en_clr(en_clr),
    .stat_wr(stat_wr), .prog_req(prog_req), .prog_base(prog_base));

// File: tb/sim_spi_mem_slave.sv
module sim_spi_mem_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0;
    logic spi_so, spi_so_oe;
    logic nv_busy = 1'b0;
    logic [7:0] stat_byte = 8'h00;
    logic arr_we = 1'b0;
    logic [8:0] arr_waddr = '0;
    logic [7:0] arr_wdata = '0;
    logic en_set, en_clr, stat_wr, prog_req;
    logic [7:0] stat_wdata;
    logic [8:0] prog_base;
    logic [127:0] prog_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_mem_slave u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_si(spi_si),
        .spi_so(spi_so), .spi_so_oe(spi_so_oe), .nv_busy(nv_busy), .stat_byte(stat_byte),
        .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
        .en_set(en_set), .en_clr(en_clr), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .prog_req(prog_req), .prog_base(prog_base), .prog_data(prog_data));

    int n_vec = 0, n_bad = 0;
    bit finished = 0;
    byte unsigned ref_mem [512];
    bit txb[$];
    logic rxb [0:1023];
    logic oeb [0:1023];
    int n_set = 0, n_clr = 0, n_stw = 0, n_prog = 0;
    logic [7:0] got_stw;
    logic [8:0] got_base;
    logic [127:0] got_data;
    int cs_hi_cnt = 0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (en_set) n_set++;
        if (en_clr) n_clr++;
        if (stat_wr) begin n_stw++; got_stw = stat_wdata; end
        if (prog_req) begin n_prog++; got_base = prog_base; got_data = prog_data; end
        cs_hi_cnt <= spi_cs_n ? cs_hi_cnt + 1 : 0;
    end

    // R2: per-clock reference, output released while deselected
    always @(negedge clk) begin
        if (rst_n && cs_hi_cnt >= 4 && !finished)
            chk(spi_so_oe === 1'b0, "R2 oe while deselected", spi_so_oe, 0);
    end

    task automatic push_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) txb.push_back(b[i]);
    endtask

    task automatic xfer(input bit mode3, input bit do_fall);
        spi_sck = mode3;
        repeat (HALF) @(negedge clk);
        if (do_fall) spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < txb.size(); i++) begin
            if (mode3) spi_sck = 1'b0;
            spi_si = txb[i];
            repeat (HALF) @(negedge clk);
            rxb[i] = spi_so;
            oeb[i] = spi_so_oe;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            if (!mode3) spi_sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (3*HALF) @(negedge clk);
        txb.delete();
    endtask

    function automatic logic [7:0] rx_byte(input int start);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[7-i] = rxb[start+i];
        return v;
    endfunction

    task automatic arr_write(input int a, input logic [7:0] v);
        @(negedge clk);
        arr_we = 1'b1; arr_waddr = 9'(a); arr_wdata = v;
        @(negedge clk);
        arr_we = 1'b0;
        ref_mem[a] = v;
    endtask

    task automatic do_read(input bit mode3, input logic [15:0] aw, input int nb, input string tag);
        push_byte(8'h03); push_byte(aw[15:8]); push_byte(aw[7:0]);
        for (int j = 0; j < nb; j++) push_byte(8'h00);
        xfer(mode3, 1);
        chk(oeb[23] === 1'b0, {tag, " R2 oe before data"}, oeb[23], 0);
        chk(oeb[24] === 1'b1, {tag, " R2 oe in data"}, oeb[24], 1);
        for (int j = 0; j < nb; j++) begin
            int a = (int'(aw[8:0]) + j) % 512;
            chk(rx_byte(24 + 8*j) === ref_mem[a], {tag, " R3 read byte"}, rx_byte(24 + 8*j), ref_mem[a]);
        end
    endtask

    initial begin
        int b_set, b_clr, b_stw, b_prog;
        logic [127:0] exp_data;
        logic [7:0] pbytes [16];

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(spi_so_oe === 1'b0, "R2 reset oe", spi_so_oe, 0);
        chk({en_set, en_clr, stat_wr, prog_req} === 4'b0, "R11 reset requests",
            {en_set, en_clr, stat_wr, prog_req}, 0);

        for (int a = 0; a < 512; a++) arr_write(a, 8'((a * 37 + 11) ^ (a >> 3)));

        do_read(0, 16'h0012, 3, "R1 mode0");
        do_read(1, 16'hFFFE, 4, "R1 mode3 wrap");

        // R4 status read, not busy, two passes
        stat_byte = 8'h05;
        push_byte(8'h05); push_byte(8'h00); push_byte(8'h00);
        xfer(0, 1);
        chk(oeb[8] === 1'b1, "R2 status oe", oeb[8], 1);
        chk(rx_byte(8) === 8'h05, "R4 status first", rx_byte(8), 8'h05);
        chk(rx_byte(16) === 8'h05, "R4 status repeat", rx_byte(16), 8'h05);
        nv_busy = 1'b1;
        push_byte(8'h05); push_byte(8'h00);
        xfer(1, 1);
        chk(rx_byte(8) === 8'hFF, "R4 busy ones", rx_byte(8), 8'hFF);
        nv_busy = 1'b0;

        // R5 enable commands
        b_set = n_set; b_clr = n_clr;
        push_byte(8'h06); xfer(0, 1);
        chk(n_set == b_set + 1, "R5 set enable", n_set - b_set, 1);
        push_byte(8'h06); push_byte(8'hAA); xfer(0, 1);
        chk(n_set == b_set + 1, "R5 set with extra clocks ignored", n_set - b_set, 1);
        push_byte(8'h04); xfer(1, 1);
        chk(n_clr == b_clr + 1, "R5 clear enable", n_clr - b_clr, 1);

        // R6 status write
        b_stw = n_stw;
        push_byte(8'h01); push_byte(8'h06); xfer(0, 1);
        chk(n_stw == b_stw + 1, "R6 status write count", n_stw - b_stw, 1);
        chk(got_stw === 8'h06, "R6 status value", got_stw, 8'h06);
        push_byte(8'h01); push_byte(8'h02); push_byte(8'h07); xfer(1, 1);
        chk(got_stw === 8'h07 && n_stw == b_stw + 2, "R6 last byte wins", got_stw, 8'h07);
        push_byte(8'h01); xfer(0, 1);
        chk(n_stw == b_stw + 2, "R8 status write without data", n_stw - b_stw, 2);

        // R7 program at A=0x0A5
        b_prog = n_prog;
        push_byte(8'h02); push_byte(8'h00); push_byte(8'hA5);
        for (int k = 0; k < 16; k++) begin
            pbytes[k] = 8'(8'hC0 + k * 3);
            push_byte(pbytes[k]);
        end
        xfer(0, 1);
        exp_data = '0;
        for (int k = 0; k < 16; k++) exp_data[((5 + k) % 16)*8 +: 8] = pbytes[k];
        chk(n_prog == b_prog + 1, "R7 program request", n_prog - b_prog, 1);
        chk(got_base === 9'h0A0, "R7 sector base", got_base, 9'h0A0);
        chk(got_data === exp_data, "R7 sector data", got_data, exp_data);
        for (int s = 0; s < 16; s++) arr_write(9'h0A0 + s, got_data[s*8 +: 8]);
        do_read(1, 16'h00A0, 16, "R10 readback");

        // R8 wrong bit counts
        push_byte(8'h02); push_byte(8'h00); push_byte(8'h30);
        for (int k = 0; k < 15; k++) push_byte(8'h11);
        for (int i = 0; i < 7; i++) txb.push_back(1'b1);
        xfer(0, 1);
        chk(n_prog == b_prog + 1, "R8 program 151 bits", n_prog - b_prog, 1);
        push_byte(8'h02); push_byte(8'h00); push_byte(8'h30);
        for (int k = 0; k < 17; k++) push_byte(8'h22);
        xfer(1, 1);
        chk(n_prog == b_prog + 1, "R8 program 160 bits", n_prog - b_prog, 1);

        // R2 unknown opcode
        b_set = n_set; b_clr = n_clr; b_stw = n_stw;
        push_byte(8'h9C); push_byte(8'h06); push_byte(8'h01);
        xfer(0, 1);
        begin
            bit any_oe = 0;
            for (int i = 0; i < 24; i++) if (oeb[i] !== 1'b0) any_oe = 1;
            chk(!any_oe, "R2 unknown opcode oe", any_oe, 0);
        end
        chk(n_set == b_set && n_clr == b_clr && n_stw == b_stw && n_prog == b_prog + 1,
            "R2 unknown opcode no request", n_set - b_set, 0);

        // R9 no fall after reset
        spi_cs_n = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        repeat (5) @(negedge clk); rst_n = 1'b1;
        repeat (5) @(negedge clk);
        b_set = n_set;
        push_byte(8'h06); xfer(0, 0);
        chk(n_set == b_set, "R9 unarmed command ignored", n_set - b_set, 0);
        push_byte(8'h06); xfer(0, 1);
        chk(n_set == b_set + 1, "R9 accepted after fall", n_set - b_set, 1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule